// File: doc/BRIEF.md
# Flash Write Status Generator

This block drives the read path of a flash array while an internal program or erase is running. When an operation starts it loads a busy timer whose length depends on the operation kind. Until the timer runs out, reads do not return array contents. They return a status word instead, and the host can poll that word to find out when the write has finished.

Two status bits carry the progress. Bit 7 is a polarity flag. For a program it reads as the inverse of the written bit 7, and for any erase it reads as 0. Bit 6 is a toggle that changes on every read while the operation runs. Every other bit reads as 0 while busy.

When the timer expires, a short settle window follows. In that window bit 7 already shows its final value and the remaining bits are still masked. After the window, reads pass the array data through. Command decoding and the array update itself sit outside this block. All durations are parameters counted in clock cycles.

Top module: `flash_wstat`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `rd_data` is 0.
- R2: A clock edge with `op_start` high and `busy` low raises `busy` on the next cycle. `busy` then stays high for exactly the kind's duration: `op_kind` 2'b00 program uses PROG_CYC, 2'b01 sector erase uses SECT_CYC, 2'b10 block erase uses BLK_CYC, and 2'b11 chip erase uses CHIP_CYC.
- R3: During a program, a read returns bit 7 as the complement of bit 7 of the `op_wdata` captured at start.
- R4: During any erase kind, a read returns bit 7 as 0.
- R5: While busy, bit 6 of successive reads alternates. The first read after a start returns 0.
- R6: While busy, bits 15..8 and 5..0 of a read are 0.
- R7: An `op_start` that arrives while `busy` is high is ignored. The running operation keeps its duration, its kind and its captured data.
- R8: For SETTLE_CYC cycles after `busy` falls, a read returns bit 7 at its final value and all other bits as 0. The final value is the written bit 7 for a program and 1 for an erase. A new start accepted inside this window ends the window.
- R9: Outside an operation and its settle window, a read returns `array_data`.
- R10: `rd_data` is registered. It changes only on the cycle after a clock edge with `rd_strobe` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse that starts an internal operation |
| op_kind | input | 2 | Operation kind: 00 program, 01 sector, 10 block, 11 chip erase |
| op_wdata | input | DW | Word being programmed (bit 7 used) |
| rd_strobe | input | 1 | Read request, one per cycle |
| array_data | input | DW | Normal read data from the array |
| rd_data | output | DW | Registered read result |
| busy | output | 1 | High while the internal operation runs |

## Verification
The bench builds the block with durations of 6, 9, 11 and 14 cycles for the four kinds and a 3-cycle settle window. These short values make every timer expiry and every settle boundary reachable within a few dozen cycles. They also let a second start land in the middle of an operation and inside a settle window. Reads are issued every cycle and every other cycle, so the bench sees both back-to-back toggling and held outputs between strobes.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } op_kind_e;

  function automatic logic is_erase(input op_kind_e k);
    return k != OP_PROG;
  endfunction
endpackage

// File: rtl/wstat_timer.sv
module wstat_timer
  import flash_wstat_pkg::*;
#(
  parameter int PROG_CYC = 5000,
  parameter int SECT_CYC = 6250000,
  parameter int BLK_CYC  = 6250000,
  parameter int CHIP_CYC = 25000000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  op_kind_e kind,
  output logic     accept,
  output logic     busy,
  output logic     done
);
  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (kind)
      OP_PROG: load_val = CW'(PROG_CYC - 1);
      OP_SECT: load_val = CW'(SECT_CYC - 1);
      OP_BLK:  load_val = CW'(BLK_CYC - 1);
      default: load_val = CW'(CHIP_CYC - 1);
    endcase
  end

  assign accept = start && !busy;
  assign done   = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt_q <= load_val;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wstat_settle.sv
module wstat_settle #(
  parameter int SETTLE_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic accept,
  output logic settling
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst, done, accept};
      assign settling  = 1'b0;
    end else begin : g_cnt
      localparam int SW = $clog2(SETTLE_CYC + 1);
      logic [SW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (rst || accept)   left_q <= '0;
        else if (done)       left_q <= SW'(SETTLE_CYC);
        else if (left_q != '0) left_q <= left_q - 1'b1;
      end
      assign settling = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/wstat_readout.sv
module wstat_readout
  import flash_wstat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  op_kind_e      kind,
  input  logic          wbit7,
  input  logic          busy,
  input  logic          settling,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output op_kind_e      kind_q
);
  localparam int POL_BIT = 7;
  localparam int TOG_BIT = 6;

  logic          d7_q;
  logic          tog_q;
  logic [DW-1:0] busy_word;
  logic [DW-1:0] settle_word;

  generate
    for (genvar b = 0; b < DW; b++) begin : g_bits
      if (b == POL_BIT) begin : g_pol
        assign busy_word[b]   = is_erase(kind_q) ? 1'b0 : ~d7_q;
        assign settle_word[b] = is_erase(kind_q) ? 1'b1 : d7_q;
      end else if (b == TOG_BIT) begin : g_tog
        assign busy_word[b]   = tog_q;
        assign settle_word[b] = 1'b0;
      end else begin : g_zero
        assign busy_word[b]   = 1'b0;
        assign settle_word[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tog_q   <= 1'b0;
      d7_q    <= 1'b0;
      kind_q  <= OP_PROG;
    end else begin
      if (rd_strobe) begin
        if (busy)          rd_data <= busy_word;
        else if (settling) rd_data <= settle_word;
        else               rd_data <= array_data;
      end
      if (accept) begin
        tog_q  <= 1'b0;
        d7_q   <= wbit7;
        kind_q <= kind;
      end else if (rd_strobe && busy) begin
        tog_q <= ~tog_q;
      end
    end
  end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int DW         = 16,
  parameter int PROG_CYC   = 5000,
  parameter int SECT_CYC   = 6250000,
  parameter int BLK_CYC    = 6250000,
  parameter int CHIP_CYC   = 25000000,
  parameter int SETTLE_CYC = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic [1:0]    op_kind,
  input  logic [DW-1:0] op_wdata,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic     accept;
  logic     done;
  logic     settling;
  op_kind_e kind_in;
  op_kind_e kind_q;
  logic     unused_wdata;

  assign kind_in      = op_kind_e'(op_kind);
  assign unused_wdata = ^{op_wdata[DW-1:8], op_wdata[6:0]};

  wstat_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .BLK_CYC(BLK_CYC),   .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start(op_start), .kind(kind_in),
    .accept(accept), .busy(busy), .done(done)
  );

  wstat_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .done(done), .accept(accept), .settling(settling)
  );

  wstat_readout #(.DW(DW)) u_read (
    .clk(clk), .rst(rst), .accept(accept), .kind(kind_in),
    .wbit7(op_wdata[7]), .busy(busy), .settling(settling),
    .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data), .kind_q(kind_q)
  );
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk
  import flash_wstat_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          op_start,
  input logic          rd_strobe,
  input logic          busy,
  input logic [DW-1:0] rd_data,
  input op_kind_e      kind_q
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst)                    first_q <= 1'b0;
    else if (op_start && !busy) first_q <= 1'b1;
    else if (busy && rd_strobe) first_q <= 1'b0;
  end

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    op_start && !busy |=> busy);

  assert_erase_pol_zero_R4: assert property (@(posedge clk) disable iff (rst)
    busy && rd_strobe && kind_q != OP_PROG |=> !rd_data[7]);

  assert_first_toggle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    busy && rd_strobe && first_q |=> !rd_data[6]);

  assert_other_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
    busy && rd_strobe |=> (rd_data[DW-1:8] == '0) && (rd_data[5:0] == '0));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    busy && op_start |=> $stable(kind_q));

  assert_hold_no_read_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
endmodule

bind flash_wstat flash_wstat_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_start(op_start), .rd_strobe(rd_strobe),
  .busy(busy), .rd_data(rd_data), .kind_q(kind_q)
);

// File: tb/tb_flash_wstat.sv
module tb_flash_wstat;
  localparam int DW = 16;
  localparam int P_CYC = 6, S_CYC = 9, B_CYC = 11, C_CYC = 14, ST_CYC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_start = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [DW-1:0] op_wdata = '0;
  logic rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic busy;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0;

  // reference model state
  int m_busy = 0, m_settle = 0, m_kind = 0;
  bit m_tog = 0, m_d7 = 0;
  logic [DW-1:0] m_rd = '0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  flash_wstat #(.DW(DW), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .BLK_CYC(B_CYC),
    .CHIP_CYC(C_CYC), .SETTLE_CYC(ST_CYC)) dut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_wdata(op_wdata), .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data), .busy(busy));

  function automatic int dur(input int k);
    case (k)
      0: return P_CYC;
      1: return S_CYC;
      2: return B_CYC;
      default: return C_CYC;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit b;
    cyc++;
    started = 1;
    if (rst) begin
      m_busy = 0; m_settle = 0; m_tog = 0; m_d7 = 0; m_kind = 0; m_rd = '0; m_tag = "R1";
    end else begin
      b = (m_busy > 0);
      if (rd_strobe) begin
        if (b) begin
          m_rd = '0;
          m_rd[7] = (m_kind == 0) ? ~m_d7 : 1'b0;
          m_rd[6] = m_tog;
          m_tag = (m_kind == 0) ? "R3 R5 R6" : "R4 R5 R6";
          m_tog = ~m_tog;
        end else if (m_settle > 0) begin
          m_rd = '0;
          m_rd[7] = (m_kind == 0) ? m_d7 : 1'b1;
          m_tag = "R8";
        end else begin
          m_rd = array_data;
          m_tag = "R9";
        end
      end else m_tag = "R10";
      if (b) begin
        m_busy--;
        if (m_busy == 0) m_settle = ST_CYC;
      end else if (m_settle > 0) m_settle--;
      if (op_start && !b) begin
        m_busy = dur(op_kind); m_kind = op_kind; m_d7 = op_wdata[7];
        m_tog = 0; m_settle = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(busy == (m_busy > 0), "R2", {15'b0, busy}, {15'b0, m_busy > 0});
      check(rd_data == m_rd, m_tag, rd_data, m_rd);
    end
    array_data <= DW'(cyc * 16'h1357) ^ 16'hA5C3;
  end

  task automatic run_op(input int k, input logic [DW-1:0] d, input int gap, input int restart_at);
    int n = 0;
    @(negedge clk);
    op_start = 1; op_kind = 2'(k); op_wdata = d;
    @(negedge clk);
    op_start = 0;
    while (busy) begin
      n++;
      rd_strobe = (n % gap == 0);
      if (n == restart_at) begin
        op_start = 1; op_kind = 2'(~k); op_wdata = ~d;
      end else op_start = 0;
      @(negedge clk);
    end
    op_start = 0; rd_strobe = 0;
    // R2 and R7: busy lasted exactly the duration of the first kind
    check(n == dur(k), (restart_at > 0) ? "R7" : "R2", DW'(n), DW'(dur(k)));
    for (int i = 0; i < ST_CYC + 2; i++) begin
      rd_strobe = 1;
      @(negedge clk);
    end
    rd_strobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state seen right after reset
    check(busy == 1'b0 && rd_data == '0, "R1", rd_data, '0);
    repeat (4) begin rd_strobe = 1; @(negedge clk); end
    rd_strobe = 0;
    run_op(0, 16'h0080, 1, 0);   // R3 program, bit 7 set
    run_op(0, 16'h7F7F, 2, 0);   // R3 program, bit 7 clear, sparse reads R10
    run_op(1, 16'hFFFF, 1, 0);   // R4 sector erase
    run_op(2, 16'h0000, 3, 0);   // R4 block erase
    run_op(3, 16'h1234, 1, 0);   // R4 chip erase
    run_op(0, 16'h00FF, 1, 2);   // R7 restart while busy
    run_op(1, 16'h0000, 1, 4);   // R7 restart during erase
    // R8: new start accepted inside settle window
    @(negedge clk);
    op_start = 1; op_kind = 2'b00; op_wdata = 16'h0080;
    @(negedge clk);
    op_start = 0;
    while (busy) @(negedge clk);
    rd_strobe = 1; @(negedge clk);
    op_start = 1; op_kind = 2'b01; @(negedge clk);
    op_start = 0;
    repeat (S_CYC + ST_CYC + 3) @(negedge clk);
    rd_strobe = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule